// File: doc/BRIEF.md
# Programmable Dual Serial CRC Engine

This block keeps two running CRC values beside a serial link: one over the bits the link shifts out, and one over the bits it shifts in. Both values use a single generator polynomial that software sets at run time. A length select picks either an 8-bit or a 16-bit CRC, so the block can compute any CRC-8 or CRC-16 variant with a zero start value.

The surrounding link controller strobes `shift_en` once per bit time and presents the outgoing and incoming bits. Writing 1 to the enable control bit switches calculation on and clears both accumulators. Writing 0 switches it off, and both values then hold. While the link runs in its audio-serial mode, the CRC logic stays frozen. The results reach a register interface through output registers. These registers only refresh while the link reports it is not busy, so a readout is stable whenever the link is idle.

Top module: `dual_crc_engine`

## Requirements
- R1: After reset, both accumulators and both outputs `tx_crc` and `rx_crc` are 0x0000.
- R2: A cycle with `en_wr`=1 and `en_wdata`=1 clears both accumulators to 0x0000 and turns calculation on, whether or not calculation was already on.
- R3: A cycle with `en_wr`=1 and `en_wdata`=0 turns calculation off. After that, both accumulators hold their values whatever `shift_en` does.
- R4: An accumulator changes only on a clock edge where `shift_en`=1, calculation is on and `audio_mode`=0, or on a clear. At every other edge it holds.
- R5: With `wide_sel`=1, each step works MSB-first over all 16 bits. The feedback bit is the data bit XOR accumulator bit 15. The next value is the accumulator shifted left by one, XORed with `poly` when the feedback bit is 1. With polynomial 0x1021 and the ASCII bytes "123456789" sent MSB-first, the result is 0x31C3.
- R6: With `wide_sel`=0, only `poly[7:0]` is used and the top bit is bit 7. After each step, bits 15:8 of the accumulator are zero. With `poly`=0xAB07 and "123456789", the result is 0x00F4.
- R7: The transmit accumulator takes only `tx_bit`, and the receive accumulator takes only `rx_bit`. The two are fully independent.
- R8: While `audio_mode`=1, shift strobes do not change either accumulator.
- R9: On each edge where `busy`=0, the outputs load the accumulator values from before that edge. While `busy`=1, the outputs hold.
- R10: When a clear and a shift strobe fall on the same edge, the clear wins and the accumulator becomes 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| shift_en | input | 1 | One strobe per serial bit time |
| tx_bit | input | 1 | Bit shifted out on this strobe |
| rx_bit | input | 1 | Bit shifted in on this strobe |
| poly | input | 16 | Generator polynomial, implicit top term omitted |
| wide_sel | input | 1 | 1 = 16-bit CRC, 0 = 8-bit CRC |
| en_wr | input | 1 | Write strobe for the enable control bit |
| en_wdata | input | 1 | Value written to the enable bit |
| busy | input | 1 | Link is transferring; outputs hold |
| audio_mode | input | 1 | Link is in audio-serial mode; CRC frozen |
| tx_crc | output | 16 | Transmit CRC readout |
| rx_crc | output | 16 | Receive CRC readout |

## Verification
A wrong accumulator bit cannot stay hidden. It reaches `tx_crc` or `rx_crc` on the first edge after it forms, as long as `busy` is low. The bench compares both outputs on every clock, so a fault is caught within two cycles of the stimulus that exposes it. Only a fault that arises while `busy` is high waits until the link goes idle. Faults in the feedback taps, the 8-bit masking or the clear priority each give a wrong value within one byte of stream, because every polynomial and length is driven with changing data.

// File: rtl/crc_pkg.sv
package crc_pkg;
  localparam int CRC_W    = 16;
  localparam int NARROW_W = 8;
  localparam int N_LANES  = 2;
  localparam int LANE_TX  = 0;
  localparam int LANE_RX  = 1;

  typedef struct packed {
    logic clear;
    logic step;
  } lane_cmd_t;
endpackage

// File: rtl/crc_ctrl.sv
module crc_ctrl
  import crc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      shift_en,
  input  logic      en_wr,
  input  logic      en_wdata,
  input  logic      audio_mode,
  output lane_cmd_t cmd,
  output logic      enabled
);
  logic en_q;

  always_ff @(posedge clk) begin
    if (rst)        en_q <= 1'b0;
    else if (en_wr) en_q <= en_wdata;
  end

  always_comb begin
    cmd.clear = en_wr & en_wdata;
    cmd.step  = shift_en & en_q & ~audio_mode & ~cmd.clear;
  end

  assign enabled = en_q;
endmodule

// File: rtl/crc_lane.sv
module crc_lane #(
  parameter int W  = 16,
  parameter int NW = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         step,
  input  logic         wide,
  input  logic         din,
  input  logic [W-1:0] poly,
  output logic [W-1:0] acc
);
  localparam logic [W-1:0] NMASK = {{(W-NW){1'b0}}, {NW{1'b1}}};

  logic [W-1:0] acc_q, poly_eff, nxt;
  logic         top_bit, fb;

  always_comb begin
    poly_eff = wide ? poly : (poly & NMASK);
    top_bit  = wide ? acc_q[W-1] : acc_q[NW-1];
    fb       = din ^ top_bit;
    nxt      = {acc_q[W-2:0], 1'b0} ^ (fb ? poly_eff : '0);
    if (!wide) nxt = nxt & NMASK;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) acc_q <= '0;
    else if (step)    acc_q <= nxt;
  end

  assign acc = acc_q;
endmodule

// File: rtl/crc_readout.sv
module crc_readout #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hold,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (!hold) q <= d;
  end
endmodule

// File: rtl/dual_crc_engine.sv
module dual_crc_engine
  import crc_pkg::*;
#(
  parameter int W  = CRC_W,
  parameter int NW = NARROW_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         tx_bit,
  input  logic         rx_bit,
  input  logic [W-1:0] poly,
  input  logic         wide_sel,
  input  logic         en_wr,
  input  logic         en_wdata,
  input  logic         busy,
  input  logic         audio_mode,
  output logic [W-1:0] tx_crc,
  output logic [W-1:0] rx_crc
);
  lane_cmd_t    cmd;
  logic         crc_enabled;
  logic [W-1:0] lane_acc [N_LANES];
  logic [W-1:0] lane_out [N_LANES];
  logic         lane_din [N_LANES];
  logic [W-1:0] tx_acc, rx_acc;

  crc_ctrl u_ctrl (
    .clk(clk), .rst(rst), .shift_en(shift_en), .en_wr(en_wr),
    .en_wdata(en_wdata), .audio_mode(audio_mode),
    .cmd(cmd), .enabled(crc_enabled)
  );

  always_comb begin
    lane_din[LANE_TX] = tx_bit;
    lane_din[LANE_RX] = rx_bit;
  end

  for (genvar i = 0; i < N_LANES; i++) begin : g_lane
    crc_lane #(.W(W), .NW(NW)) u_lane (
      .clk(clk), .rst(rst), .clear(cmd.clear), .step(cmd.step),
      .wide(wide_sel), .din(lane_din[i]), .poly(poly), .acc(lane_acc[i])
    );
    crc_readout #(.W(W)) u_out (
      .clk(clk), .rst(rst), .hold(busy), .d(lane_acc[i]), .q(lane_out[i])
    );
  end

  assign tx_acc = lane_acc[LANE_TX];
  assign rx_acc = lane_acc[LANE_RX];
  assign tx_crc = lane_out[LANE_TX];
  assign rx_crc = lane_out[LANE_RX];
endmodule

// File: rtl/dual_crc_checker.sv
module dual_crc_checker #(
  parameter int W  = 16,
  parameter int NW = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         shift_en,
  input logic         en_wr,
  input logic         en_wdata,
  input logic         busy,
  input logic         audio_mode,
  input logic         wide_sel,
  input logic         crc_enabled,
  input logic [W-1:0] tx_acc,
  input logic [W-1:0] rx_acc,
  input logic [W-1:0] tx_crc,
  input logic [W-1:0] rx_crc
);
  a_r1_reset_zero: assert property (@(posedge clk)
    rst |=> (tx_crc == '0 && rx_crc == '0 && tx_acc == '0 && rx_acc == '0));

  a_r2_clear_both: assert property (@(posedge clk) disable iff (rst)
    (en_wr && en_wdata) |=> (tx_acc == '0 && rx_acc == '0 && crc_enabled));

  a_r3_off_hold: assert property (@(posedge clk) disable iff (rst)
    (!crc_enabled && !en_wr) |=> ($stable(tx_acc) && $stable(rx_acc)));

  a_r4_no_strobe_hold: assert property (@(posedge clk) disable iff (rst)
    (!shift_en && !en_wr) |=> ($stable(tx_acc) && $stable(rx_acc)));

  a_r8_audio_freeze: assert property (@(posedge clk) disable iff (rst)
    (audio_mode && !en_wr) |=> ($stable(tx_acc) && $stable(rx_acc)));

  a_r6_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (!wide_sel && shift_en && crc_enabled && !audio_mode && !en_wr)
      |=> (tx_acc[W-1:NW] == '0 && rx_acc[W-1:NW] == '0));

  a_r9_busy_hold: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(tx_crc) && $stable(rx_crc)));

  a_r9_idle_follow: assert property (@(posedge clk) disable iff (rst)
    !busy |=> (tx_crc == $past(tx_acc) && rx_crc == $past(rx_acc)));
endmodule

bind dual_crc_engine dual_crc_checker #(.W(W), .NW(NW)) u_chk (
  .clk(clk), .rst(rst), .shift_en(shift_en), .en_wr(en_wr),
  .en_wdata(en_wdata), .busy(busy), .audio_mode(audio_mode),
  .wide_sel(wide_sel), .crc_enabled(crc_enabled),
  .tx_acc(tx_acc), .rx_acc(rx_acc), .tx_crc(tx_crc), .rx_crc(rx_crc)
);

// File: tb/tb_dual_crc_engine.sv
module tb_dual_crc_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        shift_en = 0, tx_bit = 0, rx_bit = 0;
  logic [15:0] poly = 16'h1021;
  logic        wide_sel = 1, en_wr = 0, en_wdata = 0, busy = 0, audio_mode = 0;
  logic [15:0] tx_crc, rx_crc;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dual_crc_engine dut (
    .clk(clk), .rst(rst), .shift_en(shift_en), .tx_bit(tx_bit), .rx_bit(rx_bit),
    .poly(poly), .wide_sel(wide_sel), .en_wr(en_wr), .en_wdata(en_wdata),
    .busy(busy), .audio_mode(audio_mode), .tx_crc(tx_crc), .rx_crc(rx_crc)
  );

  // Behavioural reference: one serial step, MSB-first, written with integers
  function automatic int ref_step(int a, bit d, int p, bit wide);
    int n = wide ? 16 : 8;
    int m = (1 << n) - 1;
    bit msb = a[n-1];
    return ((a << 1) & m) ^ (((d ^ msb) != 0) ? (p & m) : 0);
  endfunction

  int m_tx = 0, m_rx = 0, m_otx = 0, m_orx = 0;
  bit m_en = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_tx = 0; m_rx = 0; m_otx = 0; m_orx = 0; m_en = 0;
    end else begin
      if (!busy) begin m_otx = m_tx; m_orx = m_rx; end       // R9
      if (en_wr && en_wdata) begin m_tx = 0; m_rx = 0; end    // R2, R10
      else if (shift_en && m_en && !audio_mode) begin         // R3, R4, R8
        m_tx = ref_step(m_tx, tx_bit, int'(poly), wide_sel);  // R5, R6, R7
        m_rx = ref_step(m_rx, rx_bit, int'(poly), wide_sel);
      end
      if (en_wr) m_en = en_wdata;
    end
  end

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%04h expected=%04h", tag, act, exp);
    end
  endtask

  // Per-cycle comparison against the model (R4, R7, R9)
  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R4/R9 tx per-cycle", int'(tx_crc), m_otx);
      check("R7/R9 rx per-cycle", int'(rx_crc), m_orx);
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_en(bit v);
    en_wr = 1; en_wdata = v;
    @(negedge clk);
    en_wr = 0; en_wdata = 0;
  endtask

  task automatic send_byte(logic [7:0] t, logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      shift_en = 1; tx_bit = t[i]; rx_bit = r[i];
      @(negedge clk);
    end
    shift_en = 0;
  endtask

  task automatic send_check_string();
    string s = "123456789";
    for (int k = 0; k < 9; k++) send_byte(s[k], s[8-k]);
  endtask

  initial begin
    logic [15:0] save_t, save_r;
    idle(3);
    rst = 0;
    idle(1);
    check("R1 tx reset", int'(tx_crc), 0);
    check("R1 rx reset", int'(rx_crc), 0);

    // R5: CRC-16 known vector while busy
    wide_sel = 1; poly = 16'h1021;
    write_en(1);
    busy = 1;
    send_check_string();
    check("R9 busy hold", int'(tx_crc), 0);
    busy = 0;
    idle(2);
    check("R5 crc16 1021", int'(tx_crc), 16'h31C3);

    // R2: enable write clears both
    write_en(1);
    idle(2);
    check("R2 tx clear", int'(tx_crc), 0);
    check("R2 rx clear", int'(rx_crc), 0);

    // R6: CRC-8 with garbage upper polynomial byte
    wide_sel = 0; poly = 16'hAB07;
    send_check_string();
    idle(2);
    check("R6 crc8 07", int'(tx_crc), 16'h00F4);

    // R8: audio mode freezes
    save_t = tx_crc; save_r = rx_crc;
    audio_mode = 1;
    send_byte(8'hA5, 8'h3C);
    idle(2);
    check("R8 audio tx", int'(tx_crc), int'(save_t));
    check("R8 audio rx", int'(rx_crc), int'(save_r));
    audio_mode = 0;

    // R3: disabled holds
    write_en(0);
    send_byte(8'h5A, 8'hC3);
    idle(2);
    check("R3 off tx", int'(tx_crc), int'(save_t));
    check("R3 off rx", int'(rx_crc), int'(save_r));

    // R10: clear collides with shift strobe
    write_en(1);
    send_byte(8'h81, 8'h7E);
    shift_en = 1; tx_bit = 1; rx_bit = 1; en_wr = 1; en_wdata = 1;
    @(negedge clk);
    shift_en = 0; en_wr = 0; en_wdata = 0;
    idle(1);
    check("R10 clear wins tx", int'(tx_crc), 0);
    check("R10 clear wins rx", int'(rx_crc), 0);

    // Several polynomials in both lengths, gaps, busy toggles, mid-stream clear
    for (int p = 0; p < 8; p++) begin
      wide_sel = p[0];
      poly = 16'h8005 ^ 16'(p * 16'h1357);
      write_en(1);
      for (int b = 0; b < 12; b++) begin
        busy = (b % 3 == 1);
        send_byte(8'(b * 37 + p), 8'(b * 91 ^ p));
        if (b == 6 && p[1]) write_en(1);   // R2 mid-stream clear
        idle(b % 2);                      // R4 strobe gaps
      end
      busy = 0;
      idle(2);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=0000 expected=0001");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule